// File: doc/BRIEF.md
# Raster Line and Position Interrupt Generator

This block watches the raster position that a display timing generator reports (raster line, dot within the line and the current field) and turns programmed screen positions into single-cycle interrupt pulses. Two outputs are plain line interrupts. A third fires at a programmed dot within a line, either once per frame or periodically every N field lines. A one-shot light-gun latch records the beam position when a requested coordinate is reached and pulses a completion output.

Software programs three registers through a simple write port. The line numbers it writes count field lines, so each is doubled, plus one in the odd field, before it is compared against the raster line counter. The timing generator advances the dot input once per clock, and each pulse appears in the cycle after the one whose inputs matched. There is no streaming data path: every pin is a plain control or status signal.

Top module: `raster_irq_gen`

## Requirements
- R1: A write with select 0 loads line target A from data bits [25:16] and line target B from data bits [9:0]. Other data bits are ignored.
- R2: A line target L produces a one-cycle pulse on its output in the cycle after the inputs show raster line 2L+odd at dot 0, where odd is the field flag (0 or 1).
- R3: A line target whose doubled raster line 2L+odd is not below the total line count produces no pulse in that field.
- R4: A write with select 1 loads the position target from data bits [25:16], the mode from bits [13:12] and the line field from bits [9:0]. The position interrupt pulses in the cycle after the inputs show raster line 2T+odd at dot 2H, where T is the current target line and H the position field. Bits [15:14] are ignored.
- R5: Modes 0 and 3 hold T equal to the line field, giving one pulse per field at a fixed line.
- R6: Mode 1 sets N to the line field and T to wrap(current raster line >> 1 plus N) at the write. On each position match T becomes wrap(T+N), where wrap(x) subtracts half the total line count once when x is at least that half. N is not greater than half the total line count.
- R7: Mode 2 behaves as mode 1 with N forced to 1, whatever the line field holds.
- R8: When 2H is not below the line length, the position interrupt fires at the last dot of the line (line length minus 1).
- R9: A write with select 2 arms the light-gun latch with x from bits [9:0] and y from bits [25:16]. It triggers once at raster line (y>>1)+vsync lines and dot x+hsync width. When it triggers, the position word becomes (line<<16)|(dot & 0x3FF), the done output pulses for one cycle and the latch disarms.
- R10: While reset is asserted all pulses are low and the position word is 0. After reset all targets, x, y, N and H are zero, the mode is 0 and the latch is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | LINE_W | Current raster line |
| dot_i | input | DOT_W | Current dot within the line |
| odd_i | input | 1 | Field flag, 1 in the odd field |
| total_lines_i | input | LINE_W+1 | Raster lines per field cycle |
| line_len_i | input | DOT_W | Dots per line |
| vsync_lines_i | input | SYNC_W | Vertical sync length in lines (light-gun offset) |
| hsync_dots_i | input | DOT_W | Horizontal sync width in dots (light-gun offset) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 lines, 1 position, 2 light gun |
| wr_data_i | input | 32 | Write data |
| irq_line_a_o | output | 1 | Line A interrupt pulse |
| irq_line_b_o | output | 1 | Line B interrupt pulse |
| irq_hpos_o | output | 1 | Position interrupt pulse |
| gun_done_o | output | 1 | Light-gun capture pulse |
| gun_pos_o | output | 32 | Captured position word |

## Verification
The hardest situations to reach are a register write landing on the very edge where the periodic position target matches and advances, and a mode-1 target wrapping around half the field count while the field flag toggles. Directed phases on a 20-line, 24-dot frame set up each mode and boundary. Seeded random writes then arrive at arbitrary cycles over tens of thousands of dots, so writes collide with matches and wraps, and a second run uses an odd line count. A bench model predicts every output in every cycle.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  typedef enum logic [1:0] {
    HM_FRAME  = 2'd0,
    HM_NLINES = 2'd1,
    HM_EVERY  = 2'd2,
    HM_RSVD   = 2'd3
  } hmode_e;

  localparam logic [1:0] SEL_VERT = 2'd0;
  localparam logic [1:0] SEL_HORZ = 2'd1;
  localparam logic [1:0] SEL_GUN  = 2'd2;
endpackage

// File: rtl/raster_line_match.sv
module raster_line_match #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] field_line_i,
  input  logic [DOT_W-1:0]  dot_tgt_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_i,
  input  logic [LINE_W:0]   total_i,
  output logic              match_o,
  output logic              hit_o
);
  logic [LINE_W:0] raster;

  // Doubled field line, low bit taken from the field flag
  assign raster  = {field_line_i, odd_i};
  assign match_o = (raster < total_i) && (raster == {1'b0, line_i}) &&
                   (dot_i == dot_tgt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_o <= 1'b0;
    else        hit_o <= match_o;
  end
endmodule

// File: rtl/raster_hpos_ctl.sv
module raster_hpos_ctl
  import raster_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_i,
  input  logic [LINE_W:0]   total_i,
  input  logic [DOT_W-1:0]  line_len_i,
  output logic              hit_o
);
  localparam int TOT_W = LINE_W + 1;

  logic              per_q;
  logic [LINE_W-1:0] n_q, tgt_q, h_q;
  logic [TOT_W-1:0]  half, first_t, next_t;
  logic [LINE_W-1:0] n_sel;
  logic [DOT_W:0]    dbl;
  logic [DOT_W-1:0]  dot_tgt;
  logic              match;
  hmode_e            wr_mode;

  function automatic logic [TOT_W-1:0] wrap_half(input logic [TOT_W-1:0] x,
                                                 input logic [TOT_W-1:0] h);
    return (x >= h) ? x - h : x;
  endfunction

  assign half    = total_i >> 1;
  assign wr_mode = hmode_e'(wr_data_i[13:12]);
  assign n_sel   = (wr_mode == HM_EVERY) ? LINE_W'(1) : wr_data_i[LINE_W-1:0];
  assign first_t = wrap_half({1'b0, line_i >> 1} + {1'b0, n_sel}, half);
  assign next_t  = wrap_half({1'b0, tgt_q} + {1'b0, n_q}, half);

  // Position is programmed in units of two dots, clamped to the last dot
  assign dbl     = {{(DOT_W-LINE_W){1'b0}}, h_q, 1'b0};
  assign dot_tgt = (dbl >= {1'b0, line_len_i}) ? line_len_i - 1'b1
                                               : dbl[DOT_W-1:0];

  raster_line_match #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .field_line_i(tgt_q), .dot_tgt_i(dot_tgt),
    .line_i(line_i), .dot_i(dot_i), .odd_i(odd_i), .total_i(total_i),
    .match_o(match), .hit_o(hit_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= 1'b0;
      n_q   <= '0;
      tgt_q <= '0;
      h_q   <= '0;
    end else if (wr_i) begin
      h_q <= wr_data_i[16 +: LINE_W];
      case (wr_mode)
        HM_NLINES, HM_EVERY: begin
          per_q <= 1'b1;
          n_q   <= n_sel;
          tgt_q <= first_t[LINE_W-1:0];
        end
        default: begin
          per_q <= 1'b0;
          tgt_q <= wr_data_i[LINE_W-1:0];
        end
      endcase
    end else if (match && per_q) begin
      tgt_q <= next_t[LINE_W-1:0];
    end
  end
endmodule

// File: rtl/raster_gun_latch.sv
module raster_gun_latch #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 11,
  parameter int SYNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [SYNC_W-1:0] vsync_i,
  input  logic [DOT_W-1:0]  hsync_i,
  output logic              done_o,
  output logic [31:0]       pos_o
);
  localparam int TOT_W = LINE_W + 1;

  logic              armed_q;
  logic [LINE_W-1:0] gx_q, gy_q;
  logic [TOT_W-1:0]  t_line;
  logic [DOT_W:0]    t_dot;
  logic              trig;

  assign t_line = {1'b0, gy_q >> 1} + TOT_W'(vsync_i);
  assign t_dot  = {1'b0, DOT_W'(gx_q)} + {1'b0, hsync_i};
  assign trig   = armed_q && (t_line == {1'b0, line_i}) && (t_dot == {1'b0, dot_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gx_q    <= '0;
      gy_q    <= '0;
      done_o  <= 1'b0;
      pos_o   <= '0;
    end else begin
      done_o <= trig;
      if (trig) begin
        pos_o   <= {{(16-LINE_W){1'b0}}, line_i, 6'd0, dot_i[9:0]};
        armed_q <= 1'b0;
      end
      if (wr_i) begin
        armed_q <= 1'b1;
        gx_q    <= wr_data_i[LINE_W-1:0];
        gy_q    <= wr_data_i[16 +: LINE_W];
      end
    end
  end
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 11,
  parameter int SYNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_i,
  input  logic [LINE_W:0]   total_lines_i,
  input  logic [DOT_W-1:0]  line_len_i,
  input  logic [SYNC_W-1:0] vsync_lines_i,
  input  logic [DOT_W-1:0]  hsync_dots_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  output logic              irq_line_a_o,
  output logic              irq_line_b_o,
  output logic              irq_hpos_o,
  output logic              gun_done_o,
  output logic [31:0]       gun_pos_o
);
  localparam int NUM_VLINE = 2;

  logic                 wr_vert, wr_horz, wr_gun;
  logic [LINE_W-1:0]    vtgt_q [NUM_VLINE];
  logic [NUM_VLINE-1:0] vhit;
  logic [NUM_VLINE-1:0] vmatch_unused;

  assign wr_vert = wr_en_i && (wr_sel_i == SEL_VERT);
  assign wr_horz = wr_en_i && (wr_sel_i == SEL_HORZ);
  assign wr_gun  = wr_en_i && (wr_sel_i == SEL_GUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtgt_q[0] <= '0;
      vtgt_q[1] <= '0;
    end else if (wr_vert) begin
      vtgt_q[0] <= wr_data_i[16 +: LINE_W];
      vtgt_q[1] <= wr_data_i[0 +: LINE_W];
    end
  end

  for (genvar gi = 0; gi < NUM_VLINE; gi++) begin : g_vline
    raster_line_match #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_vmatch (
      .clk(clk), .rst_n(rst_n), .field_line_i(vtgt_q[gi]), .dot_tgt_i('0),
      .line_i(line_i), .dot_i(dot_i), .odd_i(odd_i), .total_i(total_lines_i),
      .match_o(vmatch_unused[gi]), .hit_o(vhit[gi])
    );
  end

  assign irq_line_a_o = vhit[0];
  assign irq_line_b_o = vhit[1];

  raster_hpos_ctl #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_hpos (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_horz), .wr_data_i(wr_data_i),
    .line_i(line_i), .dot_i(dot_i), .odd_i(odd_i), .total_i(total_lines_i),
    .line_len_i(line_len_i), .hit_o(irq_hpos_o)
  );

  raster_gun_latch #(.LINE_W(LINE_W), .DOT_W(DOT_W), .SYNC_W(SYNC_W)) u_gun (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_gun), .wr_data_i(wr_data_i),
    .line_i(line_i), .dot_i(dot_i), .vsync_i(vsync_lines_i),
    .hsync_i(hsync_dots_i), .done_o(gun_done_o), .pos_o(gun_pos_o)
  );
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
  import raster_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_i,
  input logic [DOT_W-1:0]  dot_i,
  input logic              odd_i,
  input logic [LINE_W:0]   total_lines_i,
  input logic [DOT_W-1:0]  line_len_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              irq_line_a_o,
  input logic              irq_line_b_o,
  input logic              irq_hpos_o,
  input logic              gun_done_o,
  input logic [31:0]       gun_pos_o
);
  assert_line_a_dot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line_a_o |-> ($past(dot_i) == '0) && ($past(line_i[0]) == $past(odd_i)));

  assert_line_b_dot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line_b_o |-> ($past(dot_i) == '0) && ($past(line_i[0]) == $past(odd_i)));

  assert_line_in_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line_a_o |-> ({1'b0, $past(line_i)} < $past(total_lines_i)));

  assert_hpos_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos_o |-> ($past(line_i[0]) == $past(odd_i)));

  assert_hpos_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos_o |-> ($past(dot_i) < $past(line_len_i)));

  assert_gun_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gun_done_o |-> (gun_pos_o[25:16] == 10'($past(line_i))) &&
                   (gun_pos_o[9:0] == $past(dot_i[9:0])));

  assert_gun_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gun_done_o && !$past(wr_en_i && (wr_sel_i == SEL_GUN)) |=> !gun_done_o);
endmodule

bind raster_irq_gen raster_irq_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) i_raster_irq_chk (.*);

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  line = '0;
  logic [10:0] dot = '0;
  logic        odd = 1'b0;
  logic [10:0] total = '0;
  logic [10:0] llen = '0;
  logic [3:0]  vs = '0;
  logic [10:0] hs = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        irq_a, irq_b, irq_h, gdone;
  logic [31:0] gpos;

  raster_irq_gen i_raster_irq_gen (
    .clk(clk), .rst_n(rst_n), .line_i(line), .dot_i(dot), .odd_i(odd),
    .total_lines_i(total), .line_len_i(llen), .vsync_lines_i(vs),
    .hsync_dots_i(hs), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .irq_line_a_o(irq_a), .irq_line_b_o(irq_b), .irq_hpos_o(irq_h),
    .gun_done_o(gdone), .gun_pos_o(gpos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string ph = "R10";
  int T = 20, D = 24, VS = 3, HS = 2;
  int ln = 0, dt = 0, od = 0;
  bit hold_rst = 1, fresh = 1;
  bit p_en = 0; int p_sel = 0; int unsigned p_data = 0;
  int m_va, m_vb, m_lt, m_n, m_h, m_per, m_arm, m_gx, m_gy;
  bit e_va, e_vb, e_h, e_g;
  int unsigned e_pos;

  function automatic bit fire(int L, int dtgt);
    int r = 2 * L + od;
    return (r < T) && (r == ln) && (dt == dtgt);
  endfunction

  function automatic int wrapf(int x);
    return (x >= T / 2) ? x - T / 2 : x;
  endfunction

  task automatic chk(string nm, int unsigned act, int unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual %h expected %h (line %0d dot %0d)", ph, nm, act, exp, ln, dt);
    end
  endtask

  task automatic model_clear();
    m_va = 0; m_vb = 0; m_lt = 0; m_n = 0; m_h = 0; m_per = 0;
    m_arm = 0; m_gx = 0; m_gy = 0;
    e_va = 0; e_vb = 0; e_h = 0; e_g = 0; e_pos = 0;
  endtask

  task automatic model_edge();
    int hd, mode, f;
    e_va = fire(m_va, 0);
    e_vb = fire(m_vb, 0);
    hd = 2 * m_h;
    if (hd >= D) hd = D - 1;
    e_h = fire(m_lt, hd);
    e_g = m_arm && (ln == (m_gy >> 1) + VS) && (dt == m_gx + HS);
    if (e_g) begin e_pos = (ln << 16) | (dt & 'h3ff); m_arm = 0; end
    if (e_h && m_per) m_lt = wrapf(m_lt + m_n);
    if (p_en) begin
      case (p_sel)
        0: begin m_va = (p_data >> 16) & 'h3ff; m_vb = p_data & 'h3ff; end
        1: begin
          mode = (p_data >> 12) & 3;
          f = p_data & 'h3ff;
          m_h = (p_data >> 16) & 'h3ff;
          if (mode == 0 || mode == 3) begin m_per = 0; m_lt = f; end
          else begin
            m_n = (mode == 2) ? 1 : f;
            m_per = 1;
            m_lt = wrapf((ln >> 1) + m_n);
          end
        end
        default: begin m_arm = 1; m_gx = p_data & 'h3ff; m_gy = (p_data >> 16) & 'h3ff; end
      endcase
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("irq_line_a", irq_a, e_va);
    chk("irq_line_b", irq_b, e_vb);
    chk("irq_hpos", irq_h, e_h);
    chk("gun_done", gdone, e_g);
    chk("gun_pos", gpos, e_pos);
    if (hold_rst) begin
      rst_n = 0; ln = 0; dt = 0; od = 0; fresh = 1;
      model_clear();
      p_en = 0;
    end else begin
      rst_n = 1;
      if (fresh) fresh = 0;
      else begin
        dt++;
        if (dt == D) begin
          dt = 0; ln++;
          if (ln == T) begin ln = 0; od ^= 1; end
        end
      end
      model_edge();
    end
    line = 10'(ln); dot = 11'(dt); odd = od[0];
    total = 11'(T); llen = 11'(D); vs = 4'(VS); hs = 11'(HS);
    wr_en = p_en; wr_sel = 2'(p_sel); wr_data = p_data;
    p_en = 0;
  endtask

  task automatic wr(int sel, int unsigned data);
    p_en = 1; p_sel = sel; p_data = data;
  endtask

  task automatic rand_write();
    int s = $urandom_range(2, 0);
    int mode, f, hh;
    case (s)
      0: p_data = ($urandom_range(T/2 + 1, 0) << 16) | $urandom_range(T/2 + 1, 0)
                  | ($urandom_range(63, 0) << 26);
      1: begin
        mode = $urandom_range(3, 0);
        f = (mode == 1) ? $urandom_range(T/2 - 1, 1) : $urandom_range(T/2, 0);
        hh = $urandom_range(D/2 + 2, 0);
        p_data = (hh << 16) | (mode << 12) | f | ($urandom_range(3, 0) << 14);
      end
      default: p_data = ($urandom_range(2 * (T - VS) - 1, 0) << 16)
                        | $urandom_range(D - HS - 1, 0);
    endcase
    p_en = 1; p_sel = s;
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd && !p_en && $urandom_range(199, 0) == 0) rand_write();
      step();
    end
  endtask

  task automatic do_reset(int t, int d, int v, int h);
    ph = "R10";
    hold_rst = 1;
    T = t; D = d; VS = v; HS = h;
    repeat (4) step();
    hold_rst = 0;
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    do_reset(20, 24, 3, 2);
    run(600, 0);
    ph = "R1"; wr(0, (3 << 16) | 5 | (32'hfc00_fc00)); run(1000, 0);
    ph = "R3"; wr(0, (12 << 16) | 10); run(1000, 0);
    ph = "R4"; wr(1, (5 << 16) | (3 << 14) | 4); run(1000, 0);
    ph = "R5"; wr(1, (6 << 16) | (3 << 12) | 2); run(1000, 0);
    ph = "R6"; wr(1, (3 << 16) | (1 << 12) | 3); run(2000, 0);
    ph = "R7"; wr(1, (1 << 16) | (2 << 12) | 7); run(1000, 0);
    ph = "R8"; wr(1, (20 << 16) | 3); run(1000, 0);
    ph = "R9"; wr(2, (8 << 16) | 5); run(1000, 0);
    wr(2, 0); run(1000, 0);
    ph = "R2"; run(30000, 1);
    do_reset(21, 17, 2, 5);
    ph = "R6"; wr(1, (4 << 16) | (1 << 12) | 9); run(1500, 0);
    ph = "R3"; wr(0, (10 << 16) | 10); run(1000, 0);
    ph = "R2"; run(30000, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule